// File: doc/BRIEF.md
# Call, Return and Interrupt Sequencer

This block owns three pieces of processor state: the program counter, the stack pointer and the status word. A decoder hands it one control command per instruction: plain step, subroutine call, subroutine return, return from interrupt, interrupt enable or interrupt disable. The block carries out the stack traffic for each command through a synchronous single-port memory. The stack grows downward. Calls and interrupt entries each take several cycles, one memory access per state.

A single interrupt request line is sampled only while the sequencer is idle, which is the boundary between two instructions. When the request is present and the enable bit (status bit 0) is set, the sequencer saves the program counter and then the status word on the stack. It then jumps to a fixed vector and installs a fixed service status word with the enable bit cleared.

Commands arrive on a valid/ready channel. The sender raises `cmd_valid` with `cmd_op` and `cmd_target` and holds all three unchanged until a clock edge at which `cmd_ready` is high. That edge is the handshake, and the command is consumed exactly once. `cmd_ready` is low while a sequence is running. It is also low in any idle cycle where an enabled request is pending, so an interrupt always wins over a command offered in the same cycle. Memory read data is expected one cycle after a read strobe.

Top module: `callret_seq`

## Requirements
- R1: After reset, `pc` equals `PC_RESET`, `sp` equals `SP_RESET`, `psw` is zero, and both `busy` and `done` are low.
- R2: The command codes are 0 step, 1 call, 2 return, 3 return-from-interrupt, 4 enable, 5 disable; codes 6 and 7 act as step. Step, enable and disable complete at the handshake edge with no memory access, no `busy` and no `done`. Each adds 1 to `pc`. Enable sets `psw[0]` and disable clears it.
- R3: A call first lowers `sp` by 1. It then writes `pc+1` to the memory at the new `sp` and loads `pc` with `cmd_target`.
- R4: A return reads the word at `sp` into `pc` and then raises `sp` by 1.
- R5: An interrupt is taken only in an idle cycle with `irq_req` high and `psw[0]` set. In that cycle `cmd_ready` is low, even with a command offered.
- R6: Interrupt entry writes `pc` at `sp-1` and then `psw` (zero-extended) at `sp-2`, leaving `sp` lowered by 2. It loads `pc` with `IRQ_VECTOR` and `psw` with `IRQ_PSW` with bit 0 cleared.
- R7: A return-from-interrupt loads `psw` from the word at `sp` and `pc` from the word at `sp+1`, leaving `sp` raised by 2.
- R8: `busy` is high in every cycle of a call, return, return-from-interrupt or interrupt entry after its first edge, and `cmd_ready` is low whenever `busy` is high. `done` is high for exactly one cycle, the first idle cycle after such a sequence, when all three registers already hold their new values.
- R9: A request is ignored while `psw[0]` is clear and while a sequence runs. An idle cycle with no handshake and no accepted request leaves `pc` and `sp` unchanged.
- R10: A command held while `cmd_ready` is low is accepted once, after the blocking sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken at this edge |
| cmd_op | input | 3 | Command code |
| cmd_target | input | PC_W | Call target address |
| irq_req | input | 1 | Interrupt request level |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | SP_W | Stack word address |
| mem_wdata | output | DW | Word to write |
| mem_rdata | input | DW | Read word, one cycle after the strobe |
| pc | output | PC_W | Program counter |
| sp | output | SP_W | Stack pointer |
| psw | output | PSW_W | Status word, bit 0 is the interrupt enable |
| busy | output | 1 | Multi-cycle sequence running |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state in the sequencer shows up at the ports within the sequence that went wrong. A missed or doubled stack step appears as a wrong `sp` or a write at the wrong address as soon as `busy` falls. A swapped pop order appears as `pc` and `psw` holding each other's saved words. A broken enable gate appears as `busy` rising, or failing to rise, one edge after the request is raised. Because every command is followed by a comparison of `pc`, `sp`, `psw` and the stack words against a model, a fault is caught no later than the end of the command that caused it.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_CALL = 3'd1,
    OP_RET  = 3'd2,
    OP_RETI = 3'd3,
    OP_EI   = 3'd4,
    OP_DI   = 3'd5
  } op_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CALL_WR, S_RET_RD, S_RET_WB,
    S_IRQ_PC, S_IRQ_PSW, S_RETI_RD, S_RETI_PSW, S_RETI_PC
  } state_t;

  typedef enum logic [1:0] {SP_HOLD, SP_DEC, SP_INC} sp_op_t;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_TGT, PC_VEC, PC_MEM} pc_sel_t;
  typedef enum logic [2:0] {PSW_HOLD, PSW_IE_ON, PSW_IE_OFF, PSW_ISR, PSW_MEM} psw_sel_t;
  typedef enum logic [1:0] {W_RET, W_PC, W_PSW} wsrc_t;

  typedef struct packed {
    sp_op_t   sp_op;
    pc_sel_t  pc_sel;
    psw_sel_t psw_sel;
    wsrc_t    wsrc;
    logic     mem_en;
    logic     mem_we;
    logic     addr_up;
    logic     cap_tgt;
    logic     fin;
    logic     busy;
    logic     ready;
  } ctl_t;

endpackage

// File: rtl/callret_sp.sv
module callret_sp #(
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  callret_pkg::sp_op_t   sp_op,
  output logic [SP_W-1:0]       sp_q,
  output logic [SP_W-1:0]       sp_up
);
  import callret_pkg::*;

  localparam logic [SP_W-1:0] ONE = SP_W'(1);

  assign sp_up = sp_q + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_RESET;
    else begin
      case (sp_op)
        SP_DEC:  sp_q <= sp_q - ONE;
        SP_INC:  sp_q <= sp_up;
        default: sp_q <= sp_q;
      endcase
    end
  end
endmodule

// File: rtl/callret_fsm.sv
module callret_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              irq_req,
  input  logic              ie,
  output callret_pkg::ctl_t ctl
);
  import callret_pkg::*;

  state_t state, state_n;
  logic   take_irq;
  op_t    op;

  assign take_irq = irq_req && ie;
  assign op       = op_t'(cmd_op);

  always_comb begin
    state_n     = state;
    ctl         = '0;
    ctl.sp_op   = SP_HOLD;
    ctl.pc_sel  = PC_HOLD;
    ctl.psw_sel = PSW_HOLD;
    ctl.wsrc    = W_RET;
    ctl.busy    = (state != S_IDLE);
    unique case (state)
      S_IDLE: begin
        ctl.ready = !take_irq;
        if (take_irq) begin
          ctl.sp_op = SP_DEC;
          state_n   = S_IRQ_PC;
        end else if (cmd_valid) begin
          case (op)
            OP_CALL: begin
              ctl.sp_op   = SP_DEC;
              ctl.cap_tgt = 1'b1;
              state_n     = S_CALL_WR;
            end
            OP_RET:  state_n = S_RET_RD;
            OP_RETI: state_n = S_RETI_RD;
            OP_EI: begin
              ctl.pc_sel  = PC_INC;
              ctl.psw_sel = PSW_IE_ON;
            end
            OP_DI: begin
              ctl.pc_sel  = PC_INC;
              ctl.psw_sel = PSW_IE_OFF;
            end
            default: ctl.pc_sel = PC_INC;
          endcase
        end
      end
      S_CALL_WR: begin
        ctl.mem_en = 1'b1;
        ctl.mem_we = 1'b1;
        ctl.wsrc   = W_RET;
        ctl.pc_sel = PC_TGT;
        ctl.fin    = 1'b1;
        state_n    = S_IDLE;
      end
      S_RET_RD: begin
        ctl.mem_en = 1'b1;
        state_n    = S_RET_WB;
      end
      S_RET_WB: begin
        ctl.pc_sel = PC_MEM;
        ctl.sp_op  = SP_INC;
        ctl.fin    = 1'b1;
        state_n    = S_IDLE;
      end
      S_IRQ_PC: begin
        ctl.mem_en = 1'b1;
        ctl.mem_we = 1'b1;
        ctl.wsrc   = W_PC;
        ctl.sp_op  = SP_DEC;
        state_n    = S_IRQ_PSW;
      end
      S_IRQ_PSW: begin
        ctl.mem_en  = 1'b1;
        ctl.mem_we  = 1'b1;
        ctl.wsrc    = W_PSW;
        ctl.pc_sel  = PC_VEC;
        ctl.psw_sel = PSW_ISR;
        ctl.fin     = 1'b1;
        state_n     = S_IDLE;
      end
      S_RETI_RD: begin
        ctl.mem_en = 1'b1;
        state_n    = S_RETI_PSW;
      end
      S_RETI_PSW: begin
        ctl.psw_sel = PSW_MEM;
        ctl.sp_op   = SP_INC;
        ctl.mem_en  = 1'b1;
        ctl.addr_up = 1'b1;
        state_n     = S_RETI_PC;
      end
      S_RETI_PC: begin
        ctl.pc_sel = PC_MEM;
        ctl.sp_op  = SP_INC;
        ctl.fin    = 1'b1;
        state_n    = S_IDLE;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_n;
  end
endmodule

// File: rtl/callret_seq.sv
module callret_seq #(
  parameter int PC_W  = 16,
  parameter int SP_W  = 8,
  parameter int PSW_W = 8,
  parameter int DW    = 16,
  parameter logic [PC_W-1:0]  PC_RESET   = '0,
  parameter logic [SP_W-1:0]  SP_RESET   = 8'h80,
  parameter logic [PC_W-1:0]  IRQ_VECTOR = 16'h0040,
  parameter logic [PSW_W-1:0] IRQ_PSW    = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [PC_W-1:0]  cmd_target,
  input  logic             irq_req,
  output logic             mem_en,
  output logic             mem_we,
  output logic [SP_W-1:0]  mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [PC_W-1:0]  pc,
  output logic [SP_W-1:0]  sp,
  output logic [PSW_W-1:0] psw,
  output logic             busy,
  output logic             done
);
  import callret_pkg::*;

  localparam logic [PC_W-1:0]  PC_ONE   = PC_W'(1);
  localparam logic [PSW_W-1:0] IE_MASK  = PSW_W'(1);
  localparam logic [PSW_W-1:0] ISR_WORD = IRQ_PSW & ~IE_MASK;

  ctl_t             ctl;
  logic [SP_W-1:0]  sp_up;
  logic [PC_W-1:0]  tgt_q;
  logic [PC_W-1:0]  pc_ret;

  callret_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .irq_req   (irq_req),
    .ie        (psw[0]),
    .ctl       (ctl)
  );

  callret_sp #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .sp_op (ctl.sp_op),
    .sp_q  (sp),
    .sp_up (sp_up)
  );

  assign pc_ret    = pc + PC_ONE;
  assign cmd_ready = ctl.ready;
  assign busy      = ctl.busy;
  assign mem_en    = ctl.mem_en;
  assign mem_we    = ctl.mem_we;
  assign mem_addr  = ctl.addr_up ? sp_up : sp;

  always_comb begin
    case (ctl.wsrc)
      W_PC:    mem_wdata = DW'(pc);
      W_PSW:   mem_wdata = DW'(psw);
      default: mem_wdata = DW'(pc_ret);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= PC_RESET;
      psw   <= '0;
      tgt_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.fin;
      if (ctl.cap_tgt) tgt_q <= cmd_target;
      case (ctl.pc_sel)
        PC_INC:  pc <= pc_ret;
        PC_TGT:  pc <= tgt_q;
        PC_VEC:  pc <= IRQ_VECTOR;
        PC_MEM:  pc <= mem_rdata[PC_W-1:0];
        default: pc <= pc;
      endcase
      case (ctl.psw_sel)
        PSW_IE_ON:  psw <= psw | IE_MASK;
        PSW_IE_OFF: psw <= psw & ~IE_MASK;
        PSW_ISR:    psw <= ISR_WORD;
        PSW_MEM:    psw <= mem_rdata[PSW_W-1:0];
        default:    psw <= psw;
      endcase
    end
  end
endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk #(
  parameter int PC_W  = 16,
  parameter int SP_W  = 8,
  parameter int PSW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [2:0]       cmd_op,
  input logic             irq_req,
  input logic             mem_en,
  input logic             mem_we,
  input logic [PC_W-1:0]  pc,
  input logic [SP_W-1:0]  sp,
  input logic [PSW_W-1:0] psw,
  input logic             busy,
  input logic             done
);
  logic cmd_ok, irq_take;
  assign cmd_ok   = cmd_valid && cmd_ready;
  assign irq_take = !busy && irq_req && psw[0];

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_irq_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (!cmd_ready ##1 busy));

  p_write_strobed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  p_call_sp_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && cmd_op == 3'd1) |=> (sp == SP_W'($past(sp) - 1'b1)));

  p_step_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && (cmd_op == 3'd0 || cmd_op == 3'd4 || cmd_op == 3'd5))
      |=> (pc == PC_W'($past(pc) + 1'b1)) && !busy);

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_ok && !irq_take) |=> ($stable(pc) && $stable(sp)));
endmodule

bind callret_seq callret_seq_chk #(.PC_W(PC_W), .SP_W(SP_W), .PSW_W(PSW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .irq_req(irq_req), .mem_en(mem_en), .mem_we(mem_we),
  .pc(pc), .sp(sp), .psw(psw), .busy(busy), .done(done)
);

// File: tb/callret_seq_test.sv
module callret_seq_test;
  localparam int PW = 16, SW = 8, FW = 8, DW = 16;
  localparam logic [PW-1:0] VEC  = 16'h0040;
  localparam logic [FW-1:0] ISRP = 8'h80;
  localparam logic [SW-1:0] SPR  = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, irq_req = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [PW-1:0] cmd_target = '0;
  logic cmd_ready, mem_en, mem_we, busy, done;
  logic [SW-1:0] mem_addr, sp;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [PW-1:0] pc;
  logic [FW-1:0] psw;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_mem [256];
  logic [PW-1:0] exp_pc;
  logic [SW-1:0] exp_sp;
  logic [FW-1:0] exp_psw;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  callret_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_target(cmd_target), .irq_req(irq_req),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc(pc), .sp(sp),
    .psw(psw), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  function automatic logic [FW-1:0] isr_word();
    return ISRP & ~FW'(1);
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    chk({tag, " pc"}, 32'(pc), 32'(exp_pc));
    chk({tag, " sp"}, 32'(sp), 32'(exp_sp));
    chk({tag, " psw"}, 32'(psw), 32'(exp_psw));
  endtask

  task automatic issue(input logic [2:0] op, input logic [PW-1:0] tgt, input string tag);
    bit multi;
    multi = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_target = tgt;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    case (op)
      3'd1: begin exp_sp--; exp_mem[exp_sp] = DW'(exp_pc + 1'b1); exp_pc = tgt; multi = 1'b1; end
      3'd2: begin exp_pc = exp_mem[exp_sp]; exp_sp++; multi = 1'b1; end
      3'd3: begin
        exp_psw = exp_mem[exp_sp][FW-1:0]; exp_sp++;
        exp_pc = exp_mem[exp_sp]; exp_sp++; multi = 1'b1;
      end
      3'd4: begin exp_psw[0] = 1'b1; exp_pc++; end
      3'd5: begin exp_psw[0] = 1'b0; exp_pc++; end
      default: exp_pc++;
    endcase
    if (multi) begin
      chk({tag, " busy during sequence R8"}, 32'(busy), 1);
      while (busy) @(negedge clk);
      chk({tag, " done pulse R8"}, 32'(done), 1);
    end else begin
      chk({tag, " single-cycle no busy/done R2"}, {busy, done}, 0);
    end
    check_regs(tag);
    if (op == 3'd1) chk({tag, " pushed return R3"}, 32'(mem[exp_sp]), 32'(exp_mem[exp_sp]));
  endtask

  task automatic irq_try(input string tag);
    @(negedge clk);
    irq_req = 1'b1;
    if (exp_psw[0]) begin
      @(negedge clk);
      chk({tag, " entry starts R5"}, 32'(busy), 1);
      irq_req = 1'b0;
      exp_sp--; exp_mem[exp_sp] = DW'(exp_pc);
      exp_sp--; exp_mem[exp_sp] = DW'(exp_psw);
      exp_pc = VEC; exp_psw = isr_word();
      while (busy) @(negedge clk);
      chk({tag, " entry done R8"}, 32'(done), 1);
      check_regs({tag, " entry R6"});
      chk({tag, " saved pc R6"}, 32'(mem[exp_sp + 1'b1]), 32'(exp_mem[exp_sp + 1'b1]));
      chk({tag, " saved psw R6"}, 32'(mem[exp_sp]), 32'(exp_mem[exp_sp]));
    end else begin
      repeat (3) @(negedge clk);
      chk({tag, " masked request ignored R9"}, 32'(busy), 0);
      check_regs({tag, " masked R9"});
      irq_req = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = DW'(i * 37 + 5);
      exp_mem[i] = DW'(i * 37 + 5);
    end
    exp_pc = '0; exp_sp = SPR; exp_psw = '0;
    repeat (3) @(negedge clk);
    chk("reset state R1", {pc, sp, psw, busy, done}, {16'h0, SPR, 8'h0, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    chk("idle ready R1", 32'(cmd_ready), 1);

    issue(3'd0, '0, "step R2");
    issue(3'd7, '0, "code 7 as step R2");
    irq_try("request with enable clear R9");
    issue(3'd1, 16'h1234, "call R3");
    issue(3'd1, 16'h2000, "nested call R3");
    issue(3'd2, '0, "return R4");
    issue(3'd2, '0, "return R4 second");
    issue(3'd4, '0, "enable R2");
    irq_try("entry R6");
    issue(3'd3, '0, "return from interrupt R7");

    // R5 and R10: request and command offered together, request wins
    @(negedge clk);
    irq_req = 1'b1; cmd_valid = 1'b1; cmd_op = 3'd0;
    #0.1;
    chk("command blocked by request R5", 32'(cmd_ready), 0);
    @(negedge clk);
    chk("entry taken first R5", 32'(busy), 1);
    irq_req = 1'b0;
    exp_sp--; exp_mem[exp_sp] = DW'(exp_pc);
    exp_sp--; exp_mem[exp_sp] = DW'(exp_psw);
    exp_pc = VEC; exp_psw = isr_word();
    while (busy) @(negedge clk);
    chk("held command ready again R10", 32'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    exp_pc++;
    check_regs("held command taken once R10");
    issue(3'd3, '0, "return after held R7");

    // R9: request raised mid-sequence is not taken until idle
    issue(3'd4, '0, "enable again R2");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0; irq_req = 1'b1;
    chk("request during return not taken R9", 32'(busy), 1);
    exp_pc = exp_mem[exp_sp]; exp_sp++;
    @(negedge clk);
    chk("return still reading R9", 32'(busy), 1);
    @(negedge clk);
    chk("return result before entry R4", 32'(pc), 32'(exp_pc));
    @(negedge clk);
    chk("entry after return R9", 32'(busy), 1);
    irq_req = 1'b0;
    exp_sp--; exp_mem[exp_sp] = DW'(exp_pc);
    exp_sp--; exp_mem[exp_sp] = DW'(exp_psw);
    exp_pc = VEC; exp_psw = isr_word();
    while (busy) @(negedge clk);
    check_regs("entry after return R6");

    for (int n = 0; n < 300; n++) begin
      int unsigned r;
      r = $urandom % 9;
      case (r)
        0, 1: issue(3'd1, PW'($urandom), "random call R3");
        2:    issue(3'd2, '0, "random return R4");
        3:    issue(3'd3, '0, "random reti R7");
        4:    issue(3'd4, '0, "random enable R2");
        5:    issue(3'd5, '0, "random disable R2");
        6:    issue(3'(6 + ($urandom % 2)), '0, "random spare code R2");
        7:    issue(3'd0, '0, "random step R2");
        default: irq_try("random request R6");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule